// File: doc/BRIEF.md
# Octant Tangential Coil Code Generator

This block turns a committed 10-bit pointer angle into two signed drive codes, one for each coil of a crossed-coil meter movement. The angle word splits into an octant index (three upper bits) and a position within that 45° span (seven lower bits). In every octant one coil sits at full scale with a fixed polarity while the other coil carries a magnitude that ramps linearly with the position field. This is a tangent-style approximation rather than a sine/cosine table. The varying magnitude climbs in even octants and falls in odd ones, so the pointer sweeps smoothly across octant boundaries.

A one-cycle load strobe captures the angle and registers the new drive codes. Between strobes the codes hold. A driver-enable input forces both outputs to zero without disturbing the stored codes. The downstream DAC and bridge stages take the sign and magnitude pairs as they are.

Top module: `octant_coil_codegen`

## Requirements
- R1: The angle splits into octant = angle[9:7] and step = angle[6:0], which gives 1024 angle codes over the full circle.
- R2: Each coil output is a polarity bit (1 = negative) and a 9-bit magnitude, and full scale is 256. Angle 0 gives sine +1 and cosine +256 (a half-step offset), and angle 1023 gives sine -1 and cosine +256.
- R3: Polarity by octant is as follows. Octants 0 and 1: sine +, cosine +. Octants 2 and 3: sine +, cosine -. Octants 4 and 5: sine -, cosine -. Octants 6 and 7: sine -, cosine +.
- R4: The sine coil varies in octants 0, 3, 4 and 7, and the cosine coil varies in octants 1, 2, 5 and 6. In every octant the other coil reads exactly 256.
- R5: In octants 0, 2, 4 and 6 the varying magnitude is 2·step+1.
- R6: In octants 1, 3, 5 and 7 the varying magnitude is 255-2·step.
- R7: The outputs take the codes for angle_i sampled at a clock edge where load_i is high, and they are visible after that edge. With load_i low, the outputs hold whatever angle_i does.
- R8: With enable_i low, both magnitudes and both polarity bits read 0 in the same cycle. A load taken while enable_i is low is still stored and appears once enable_i returns high.
- R9: After reset, and before the first load, both coils read polarity 0 and magnitude 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe that captures angle_i |
| enable_i | input | 1 | Driver enable; low forces outputs to zero |
| angle_i | input | 10 | Angle word: octant in [9:7], step in [6:0] |
| sin_neg_o | output | 1 | Sine coil polarity, 1 = negative |
| sin_mag_o | output | 9 | Sine coil magnitude, 0..256 |
| cos_neg_o | output | 1 | Cosine coil polarity, 1 = negative |
| cos_mag_o | output | 9 | Cosine coil magnitude, 0..256 |

## Verification
The hardest situation to reach is a load taken while the drivers are disabled. The stored codes cannot be seen at that moment, so the only evidence of a correct update is what appears after enable_i rises again. The bench loads one angle while enabled, loads a different angle with enable_i low, and confirms that the outputs read zero in the meantime. It then raises enable_i and expects the second angle's codes without another strobe. The octant seams are reached by a sweep over all 1024 angles, compared with an arithmetic model. Hand-worked literal values at each 45° point back up the model.

// File: rtl/coil_pkg.sv
package coil_pkg;

   // Control fields decoded from the octant index
   typedef struct packed {
      logic sin_varies;  // 1: sine coil ramps, cosine coil at full scale
      logic rising;      // 1: magnitude grows with step
      logic sin_neg;
      logic cos_neg;
   } octant_ctl_t;

   localparam int unsigned OCT_W = 3;

endpackage

// File: rtl/coil_octant_decode.sv
module coil_octant_decode
   import coil_pkg::*;
(
   input  logic [OCT_W-1:0] octant_i,
   output octant_ctl_t      ctl_o
);

   always_comb begin
      ctl_o.rising     = ~octant_i[0];
      ctl_o.sin_varies = ~(octant_i[0] ^ octant_i[1]);
      ctl_o.sin_neg    = octant_i[2];
      ctl_o.cos_neg    = octant_i[2] ^ octant_i[1];
   end

endmodule

// File: rtl/coil_ramp.sv
module coil_ramp #(
   parameter int unsigned FRAC_W = 7,
   localparam int unsigned MAG_W = FRAC_W + 2
) (
   input  logic [FRAC_W-1:0] step_i,
   input  logic              rising_i,
   output logic [MAG_W-1:0]  mag_o
);

   // 2*step+1 when rising, (2^(FRAC_W+1)-1) - 2*step when falling
   logic [FRAC_W:0] odd_val;

   always_comb begin
      odd_val = rising_i ? {step_i, 1'b1} : {~step_i, 1'b1};
      mag_o   = {1'b0, odd_val};
   end

endmodule

// File: rtl/coil_channel.sv
module coil_channel
   import coil_pkg::*;
#(
   parameter int unsigned FRAC_W = 7,
   parameter bit          IS_SIN = 1'b1,
   localparam int unsigned MAG_W = FRAC_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              enable_i,
   input  logic [FRAC_W-1:0] step_i,
   input  octant_ctl_t       ctl_i,
   output logic              neg_o,
   output logic [MAG_W-1:0]  mag_o
);

   localparam logic [MAG_W-1:0] FULL = MAG_W'(1) << (FRAC_W + 1);

   logic             varies;
   logic             sign_nx;
   logic [MAG_W-1:0] ramp_mag;
   logic [MAG_W-1:0] mag_nx;
   logic [MAG_W-1:0] mag_q;
   logic             neg_q;

   generate
      if (IS_SIN) begin : g_sin
         assign varies  = ctl_i.sin_varies;
         assign sign_nx = ctl_i.sin_neg;
      end else begin : g_cos
         assign varies  = ~ctl_i.sin_varies;
         assign sign_nx = ctl_i.cos_neg;
      end
   endgenerate

   coil_ramp #(.FRAC_W(FRAC_W)) u_ramp (
      .step_i   (step_i),
      .rising_i (ctl_i.rising),
      .mag_o    (ramp_mag)
   );

   assign mag_nx = varies ? ramp_mag : FULL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag_q <= '0;
         neg_q <= 1'b0;
      end else if (load_i) begin
         mag_q <= mag_nx;
         neg_q <= sign_nx;
      end
   end

   assign mag_o = enable_i ? mag_q : '0;
   assign neg_o = enable_i & neg_q;

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(mag_q) && $stable(neg_q)));

   // R8
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |-> (mag_o == '0 && !neg_o));

   // R2
   range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mag_q <= FULL);

   // R5
   odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (mag_q == FULL || mag_q[0]));

endmodule

// File: rtl/octant_coil_codegen.sv
module octant_coil_codegen
   import coil_pkg::*;
#(
   parameter int unsigned FRAC_W = 7,
   localparam int unsigned MAG_W = FRAC_W + 2,
   localparam int unsigned ANG_W = FRAC_W + OCT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             enable_i,
   input  logic [ANG_W-1:0] angle_i,
   output logic             sin_neg_o,
   output logic [MAG_W-1:0] sin_mag_o,
   output logic             cos_neg_o,
   output logic [MAG_W-1:0] cos_mag_o
);

   localparam logic [MAG_W-1:0] FULL = MAG_W'(1) << (FRAC_W + 1);

   generate
      if (FRAC_W < 2 || FRAC_W > 12) begin : g_bad_cfg
         $error("octant_coil_codegen: FRAC_W out of range");
      end
   endgenerate

   octant_ctl_t      ctl;
   logic [1:0]       neg_w;
   logic [MAG_W-1:0] mag_w [2];

   coil_octant_decode u_dec (
      .octant_i (angle_i[ANG_W-1 -: OCT_W]),
      .ctl_o    (ctl)
   );

   generate
      for (genvar ch = 0; ch < 2; ch++) begin : g_ch
         coil_channel #(
            .FRAC_W (FRAC_W),
            .IS_SIN (ch == 0)
         ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load_i),
            .enable_i (enable_i),
            .step_i   (angle_i[FRAC_W-1:0]),
            .ctl_i    (ctl),
            .neg_o    (neg_w[ch]),
            .mag_o    (mag_w[ch])
         );
      end
   endgenerate

   assign sin_neg_o = neg_w[0];
   assign sin_mag_o = mag_w[0];
   assign cos_neg_o = neg_w[1];
   assign cos_mag_o = mag_w[1];

   // R4
   one_var_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (!enable_i || ((sin_mag_o == FULL) != (cos_mag_o == FULL))));

   // R3
   sin_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (!enable_i || (sin_neg_o == $past(angle_i[ANG_W-1]))));

endmodule

// File: tb/tb_octant_coil_codegen.sv
module tb_octant_coil_codegen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_i = 1'b0;
   logic       enable_i = 1'b1;
   logic [9:0] angle_i = '0;
   logic       sin_neg_o, cos_neg_o;
   logic [8:0] sin_mag_o, cos_mag_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   octant_coil_codegen dut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .enable_i(enable_i),
      .angle_i(angle_i), .sin_neg_o(sin_neg_o), .sin_mag_o(sin_mag_o),
      .cos_neg_o(cos_neg_o), .cos_mag_o(cos_mag_o)
   );

   function automatic logic [19:0] pk(input bit sn, input int sm, input bit cn, input int cm);
      return {sn, 9'(sm), cn, 9'(cm)};
   endfunction

   // Expected codes built from R1, R3..R6
   function automatic logic [19:0] model(input int code);
      int oct  = code / 128;
      int step = code % 128;
      int v    = (oct % 2 == 0) ? 2 * step + 1 : 255 - 2 * step;
      bit sv   = (oct == 0 || oct == 3 || oct == 4 || oct == 7);
      bit sn   = (oct >= 4);
      bit cn   = (oct >= 2 && oct <= 5);
      return sv ? pk(sn, v, cn, 256) : pk(sn, 256, cn, v);
   endfunction

   function automatic logic [19:0] outs();
      return {sin_neg_o, sin_mag_o, cos_neg_o, cos_mag_o};
   endfunction

   task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act sin=%0d/%0d cos=%0d/%0d exp sin=%0d/%0d cos=%0d/%0d", tag,
                  act[19], act[18:10], act[9], act[8:0], exp[19], exp[18:10], exp[9], exp[8:0]);
      end
   endtask

   task automatic load_code(input int code);
      @(negedge clk);
      angle_i = 10'(code);
      load_i  = 1'b1;
      @(negedge clk);
      load_i  = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset state", outs(), '0);

      // Full sweep over every angle code
      for (int c = 0; c < 1024; c++) begin
         load_code(c);
         if ((c / 128) % 2 == 0) check($sformatf("R1 R3 R4 R5 code %0d", c), outs(), model(c));
         else                    check($sformatf("R1 R3 R4 R6 code %0d", c), outs(), model(c));
      end

      // Literal 45-degree points
      load_code(0);    check("R2 code 0",    outs(), pk(0, 1, 0, 256));
      load_code(128);  check("R2 code 128",  outs(), pk(0, 256, 0, 255));
      load_code(256);  check("R2 code 256",  outs(), pk(0, 256, 1, 1));
      load_code(384);  check("R2 code 384",  outs(), pk(0, 255, 1, 256));
      load_code(512);  check("R2 code 512",  outs(), pk(1, 1, 1, 256));
      load_code(640);  check("R2 code 640",  outs(), pk(1, 256, 1, 255));
      load_code(768);  check("R2 code 768",  outs(), pk(1, 256, 0, 1));
      load_code(896);  check("R2 code 896",  outs(), pk(1, 255, 0, 256));
      load_code(1023); check("R2 code 1023", outs(), pk(1, 1, 0, 256));

      // Hold without load
      load_code(300);
      angle_i = 10'd700;
      repeat (3) @(negedge clk);
      check("R7 hold without load", outs(), model(300));

      // Disable, load while disabled, re-enable
      enable_i = 1'b0;
      #1;
      check("R8 zero when disabled", outs(), '0);
      load_code(500);
      check("R8 zero after load while disabled", outs(), '0);
      @(negedge clk);
      enable_i = 1'b1;
      #1;
      check("R8 stored load shows on enable", outs(), model(500));
      @(negedge clk);
      check("R7 still held after enable", outs(), model(500));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule